// File: doc/BRIEF.md
# PASID-Tagged Translation Cache with Page-Selective Invalidation

This block is a small fully associative address-translation cache. Each entry carries a domain identifier, a process address space identifier (PASID), a 3-bit translation-type code, a 4 KiB page frame number, a page-size mask and the cached translation. A lookup compares its request against every entry in parallel and returns the translation one cycle later. A fill writes a new entry into a free slot. When no slot is free, a round-robin pointer picks the slot to replace.

Invalidation arrives as a two-word, 64-bit descriptor on a valid/ready port. The block decodes the page-selective-within-PASID form. It clears every matching first-stage entry in a single sweep cycle, and that sweep is visible to a lookup issued in the same cycle. A descriptor with a reserved bit set is rejected: the block flags an error and clears nothing.

Top module: `pasid_tlb`

## Requirements
- R1: After reset, every entry is invalid, `desc_ready_o` is 1, `desc_err_o` is 0, and any lookup misses.
- R2: A lookup request produces `lk_rsp_valid_o` exactly one cycle later. That response hits when a valid entry has equal domain and PASID and equal frame bits under the entry's page mask. The page mask is all ones shifted left by 9×`fill_psize_i` (0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB). The translation returned comes from the lowest-indexed matching entry.
- R3: A lookup whose domain or PASID differs from every stored entry misses.
- R4: A fill takes the lowest-indexed invalid entry. When every entry is valid, it replaces the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances only when it is used.
- R5: In word 0, the domain identifier is the field at bit 16 and the PASID is the 20-bit field at bit 32. In word 1, bits 5:0 are the address mask (AM), bit 6 is the hint, and bits from 12 upward are the page frame.
- R6: A descriptor with any reserved bit set is rejected. Reserved bits are word-0 bits outside the domain and PASID fields, and word-1 bits 11:7 or above the address width. A rejected descriptor raises `desc_err_o` for one cycle, one cycle after acceptance, and clears no entry.
- R7: An entry is cleared when its frame matches the descriptor frame in all bits at and above bit AM. This covers 2^AM contiguous 4 KiB pages.
- R8: An entry is also cleared when its stored frame equals the descriptor frame ANDed with the entry's own page mask. A descriptor address that falls inside a large page therefore removes that page.
- R9: Only entries with translation type 001 are cleared. Type 010 and type 100 entries survive.
- R10: An entry is cleared only if both its domain and its PASID equal the descriptor's.
- R11: The hint bit does not change which entries are cleared.
- R12: After a descriptor without reserved bits is accepted, `desc_ready_o` is 0 for exactly one cycle, the sweep cycle. A lookup issued in the sweep cycle already misses on every entry that the sweep clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fill_en_i | input | 1 | Write a new entry this cycle |
| fill_did_i | input | DID_W | Domain of the new entry |
| fill_pasid_i | input | PASID_W | PASID of the new entry |
| fill_ttype_i | input | 3 | Translation type (001 first-stage, 010 second-stage, 100 pass-through) |
| fill_pfn_i | input | PFN_W | Page frame of the new entry |
| fill_psize_i | input | 2 | Page size code: 0 4 KiB, 1 2 MiB, 2 1 GiB |
| fill_xlt_i | input | XLT_W | Translation to cache |
| lk_req_i | input | 1 | Lookup request |
| lk_did_i | input | DID_W | Lookup domain |
| lk_pasid_i | input | PASID_W | Lookup PASID |
| lk_pfn_i | input | PFN_W | Lookup page frame |
| lk_rsp_valid_o | output | 1 | Lookup response valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_xlt_o | output | XLT_W | Translation on hit |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Descriptor can be accepted |
| desc_w0_i | input | 64 | Descriptor word 0 |
| desc_w1_i | input | 64 | Descriptor word 1 |
| desc_err_o | output | 1 | Reserved-bit rejection pulse |

## Verification
A wrong valid bit or tag in an entry shows up at the ports on the next lookup to that page, one cycle after the request. It appears either as a hit that should be a miss or as a translation from the wrong entry. A sweep that clears too much or too little is exposed by lookups in the sweep cycle itself and just after it. These lookups are aimed at neighbouring frames, other domains, other PASIDs and entries of other translation types. A wrong replacement pointer shows as the wrong survivor after an overflowing fill, on the lookup that follows.

// File: rtl/pasid_tlb_pkg.sv
package pasid_tlb_pkg;
   localparam int DESC_W     = 64;
   localparam int PAGE_SHIFT = 12;
   localparam int LVL_BITS   = 9;

   typedef enum logic [2:0] {
      TT_FIRST  = 3'b001,
      TT_SECOND = 3'b010,
      TT_PASS   = 3'b100
   } tt_e;
endpackage

// File: rtl/pasid_tlb_desc_dec.sv
module pasid_tlb_desc_dec
   import pasid_tlb_pkg::*;
#(
   parameter int DID_W   = 16,
   parameter int PASID_W = 20,
   parameter int PFN_W   = 40
) (
   input  logic [DESC_W-1:0]  w0_i,
   input  logic [DESC_W-1:0]  w1_i,
   output logic [DID_W-1:0]   did_o,
   output logic [PASID_W-1:0] pasid_o,
   output logic [PFN_W-1:0]   pfn_o,
   output logic [PFN_W-1:0]   amask_o,
   output logic               rsv_o
);
   localparam int ADDR_W = PFN_W + PAGE_SHIFT;
   localparam logic [DESC_W-1:0] ONES    = {DESC_W{1'b1}};
   localparam logic [DESC_W-1:0] W0_USED = (~(ONES << DID_W) << 16) | (~(ONES << PASID_W) << 32);
   localparam logic [DESC_W-1:0] W1_USED = (~(ONES << ADDR_W) & ~64'hFFF) | 64'h7F;

   assign did_o   = w0_i[16 +: DID_W];
   assign pasid_o = w0_i[32 +: PASID_W];
   assign pfn_o   = w1_i[PAGE_SHIFT +: PFN_W];
   assign rsv_o   = (|(w0_i & ~W0_USED)) | (|(w1_i & ~W1_USED));

   // frame bits below the address-mask count are don't-care
   always_comb begin
      for (int i = 0; i < PFN_W; i++) begin
         amask_o[i] = (i >= int'(w1_i[5:0]));
      end
   end
endmodule

// File: rtl/pasid_tlb_entry.sv
module pasid_tlb_entry
   import pasid_tlb_pkg::*;
#(
   parameter int DID_W   = 16,
   parameter int PASID_W = 20,
   parameter int PFN_W   = 40,
   parameter int XLT_W   = 40
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_i,
   input  logic [DID_W-1:0]   wr_did_i,
   input  logic [PASID_W-1:0] wr_pasid_i,
   input  logic [2:0]         wr_ttype_i,
   input  logic [PFN_W-1:0]   wr_pfn_i,
   input  logic [1:0]         wr_psize_i,
   input  logic [XLT_W-1:0]   wr_xlt_i,
   input  logic               kill_i,
   input  logic [DID_W-1:0]   inv_did_i,
   input  logic [PASID_W-1:0] inv_pasid_i,
   input  logic [PFN_W-1:0]   inv_pfn_i,
   input  logic [PFN_W-1:0]   inv_amask_i,
   input  logic [DID_W-1:0]   lk_did_i,
   input  logic [PASID_W-1:0] lk_pasid_i,
   input  logic [PFN_W-1:0]   lk_pfn_i,
   output logic               valid_o,
   output logic               inv_hit_o,
   output logic               lk_hit_o,
   output logic [XLT_W-1:0]   xlt_o
);
   logic               valid_q;
   logic [DID_W-1:0]   did_q;
   logic [PASID_W-1:0] pasid_q;
   logic [2:0]         tt_q;
   logic [PFN_W-1:0]   pfn_q;
   logic [PFN_W-1:0]   pmask_q;
   logic [XLT_W-1:0]   xlt_q;
   logic [PFN_W-1:0]   wr_pmask;
   logic               tag_inv, tag_lk, rng_hit, big_hit;

   assign wr_pmask = {PFN_W{1'b1}} << (LVL_BITS * int'(wr_psize_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      valid_q <= 1'b0;
      else if (wr_i)    valid_q <= 1'b1;
      else if (kill_i)  valid_q <= 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (wr_i) begin
         did_q   <= wr_did_i;
         pasid_q <= wr_pasid_i;
         tt_q    <= wr_ttype_i;
         pfn_q   <= wr_pfn_i & wr_pmask;
         pmask_q <= wr_pmask;
         xlt_q   <= wr_xlt_i;
      end
   end

   assign tag_inv   = valid_q && (tt_q == TT_FIRST) && (did_q == inv_did_i) && (pasid_q == inv_pasid_i);
   assign rng_hit   = ((pfn_q ^ inv_pfn_i) & inv_amask_i) == '0;
   assign big_hit   = pfn_q == (inv_pfn_i & pmask_q);
   assign inv_hit_o = tag_inv && (rng_hit || big_hit);

   assign tag_lk    = valid_q && (did_q == lk_did_i) && (pasid_q == lk_pasid_i);
   assign lk_hit_o  = tag_lk && (((pfn_q ^ lk_pfn_i) & pmask_q) == '0);

   assign valid_o = valid_q;
   assign xlt_o   = xlt_q;
endmodule

// File: rtl/pasid_tlb_victim.sv
module pasid_tlb_victim #(
   parameter int N = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N-1:0]     valid_i,
   input  logic             alloc_i,
   output logic [IDX_W-1:0] idx_o
);
   logic [IDX_W-1:0] rr_q, free_idx;
   logic             any_free;

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   assign idx_o = any_free ? free_idx : rr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rr_q <= '0;
      else if (alloc_i && !any_free) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
   end
endmodule

// File: rtl/pasid_tlb.sv
module pasid_tlb
   import pasid_tlb_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int DID_W       = 16,
   parameter int PASID_W     = 20,
   parameter int PFN_W       = 40,
   parameter int XLT_W       = 40
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               fill_en_i,
   input  logic [DID_W-1:0]   fill_did_i,
   input  logic [PASID_W-1:0] fill_pasid_i,
   input  logic [2:0]         fill_ttype_i,
   input  logic [PFN_W-1:0]   fill_pfn_i,
   input  logic [1:0]         fill_psize_i,
   input  logic [XLT_W-1:0]   fill_xlt_i,
   input  logic               lk_req_i,
   input  logic [DID_W-1:0]   lk_did_i,
   input  logic [PASID_W-1:0] lk_pasid_i,
   input  logic [PFN_W-1:0]   lk_pfn_i,
   output logic               lk_rsp_valid_o,
   output logic               lk_hit_o,
   output logic [XLT_W-1:0]   lk_xlt_o,
   input  logic               desc_valid_i,
   output logic               desc_ready_o,
   input  logic [63:0]        desc_w0_i,
   input  logic [63:0]        desc_w1_i,
   output logic               desc_err_o
);
   localparam int IDX_W = $clog2(NUM_ENTRIES);

   if (NUM_ENTRIES < 2)           begin : g_bad_n   $error("NUM_ENTRIES must be at least 2"); end
   if (DID_W < 1 || DID_W > 16)   begin : g_bad_did $error("DID_W must be 1..16"); end
   if (PASID_W < 1 || PASID_W > 20) begin : g_bad_pw $error("PASID_W must be 1..20"); end
   if (PFN_W < 1 || PFN_W + PAGE_SHIFT > DESC_W) begin : g_bad_pfn $error("PFN_W out of range"); end

   // descriptor decode and sweep state
   logic [DID_W-1:0]   dec_did,   inv_did_q;
   logic [PASID_W-1:0] dec_pasid, inv_pasid_q;
   logic [PFN_W-1:0]   dec_pfn,   inv_pfn_q;
   logic [PFN_W-1:0]   dec_amask, inv_amask_q;
   logic               dec_rsv, busy_q, err_q, accept;

   pasid_tlb_desc_dec #(.DID_W(DID_W), .PASID_W(PASID_W), .PFN_W(PFN_W)) u_dec (
      .w0_i(desc_w0_i), .w1_i(desc_w1_i), .did_o(dec_did), .pasid_o(dec_pasid),
      .pfn_o(dec_pfn), .amask_o(dec_amask), .rsv_o(dec_rsv)
   );

   assign desc_ready_o = !busy_q;
   assign accept       = desc_valid_i && !busy_q;
   assign desc_err_o   = err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         busy_q <= accept && !dec_rsv;
         err_q  <= accept && dec_rsv;
      end
   end

   always_ff @(posedge clk_i) begin
      if (accept && !dec_rsv) begin
         inv_did_q   <= dec_did;
         inv_pasid_q <= dec_pasid;
         inv_pfn_q   <= dec_pfn;
         inv_amask_q <= dec_amask;
      end
   end

   // entry array
   logic [NUM_ENTRIES-1:0] ent_valid, ent_inv_hit, ent_lk_hit, ent_wr, ent_kill, eff_hit;
   logic [XLT_W-1:0]       ent_xlt [NUM_ENTRIES];
   logic [IDX_W-1:0]       vic_idx;

   pasid_tlb_victim #(.N(NUM_ENTRIES)) u_vic (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(ent_valid), .alloc_i(fill_en_i), .idx_o(vic_idx)
   );

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      assign ent_wr[g]   = fill_en_i && (vic_idx == IDX_W'(g));
      assign ent_kill[g] = busy_q && ent_inv_hit[g];
      pasid_tlb_entry #(.DID_W(DID_W), .PASID_W(PASID_W), .PFN_W(PFN_W), .XLT_W(XLT_W)) u_ent (
         .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(ent_wr[g]),
         .wr_did_i(fill_did_i), .wr_pasid_i(fill_pasid_i), .wr_ttype_i(fill_ttype_i),
         .wr_pfn_i(fill_pfn_i), .wr_psize_i(fill_psize_i), .wr_xlt_i(fill_xlt_i),
         .kill_i(ent_kill[g]), .inv_did_i(inv_did_q), .inv_pasid_i(inv_pasid_q),
         .inv_pfn_i(inv_pfn_q), .inv_amask_i(inv_amask_q),
         .lk_did_i(lk_did_i), .lk_pasid_i(lk_pasid_i), .lk_pfn_i(lk_pfn_i),
         .valid_o(ent_valid[g]), .inv_hit_o(ent_inv_hit[g]), .lk_hit_o(ent_lk_hit[g]),
         .xlt_o(ent_xlt[g])
      );
   end

   // entries being swept this cycle no longer answer lookups
   assign eff_hit = ent_lk_hit & ~ent_kill;

   logic [XLT_W-1:0] sel_xlt;
   always_comb begin
      sel_xlt = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (eff_hit[i]) sel_xlt = ent_xlt[i];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lk_rsp_valid_o <= 1'b0;
         lk_hit_o       <= 1'b0;
         lk_xlt_o       <= '0;
      end else begin
         lk_rsp_valid_o <= lk_req_i;
         lk_hit_o       <= lk_req_i && (|eff_hit);
         lk_xlt_o       <= sel_xlt;
      end
   end
endmodule

// File: rtl/pasid_tlb_chk.sv
module pasid_tlb_chk #(
   parameter int N = 8
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         desc_valid_i,
   input logic         desc_ready_i,
   input logic         desc_err_i,
   input logic         lk_req_i,
   input logic         lk_rsp_valid_i,
   input logic         lk_hit_i,
   input logic [N-1:0] valid_vec_i,
   input logic         busy_i
);
   p_err_needs_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      desc_err_i |-> $past(desc_valid_i && desc_ready_i));

   p_accept_outcome_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (desc_valid_i && desc_ready_i) |=> (desc_err_i ^ !desc_ready_i));

   p_sweep_one_cycle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !desc_ready_i |=> desc_ready_i);

   p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_req_i |=> lk_rsp_valid_i);

   p_hit_needs_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_hit_i |-> lk_rsp_valid_i);

   p_clear_only_in_sweep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|($past(valid_vec_i) & ~valid_vec_i)) |-> $past(busy_i));
endmodule

bind pasid_tlb pasid_tlb_chk #(.N(NUM_ENTRIES)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .desc_valid_i(desc_valid_i), .desc_ready_i(desc_ready_o),
   .desc_err_i(desc_err_o), .lk_req_i(lk_req_i), .lk_rsp_valid_i(lk_rsp_valid_o),
   .lk_hit_i(lk_hit_o), .valid_vec_i(ent_valid), .busy_i(busy_q)
);

// File: tb/pasid_tlb_tb_top.sv
module pasid_tlb_tb_top;
   localparam int N = 8, DW = 16, PW = 20, FW = 40, XW = 40;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          fill_en;
   logic [DW-1:0] fill_did;
   logic [PW-1:0] fill_pasid;
   logic [2:0]    fill_tt;
   logic [FW-1:0] fill_pfn;
   logic [1:0]    fill_psz;
   logic [XW-1:0] fill_xlt;
   logic          lk_req;
   logic [DW-1:0] lk_did;
   logic [PW-1:0] lk_pasid;
   logic [FW-1:0] lk_pfn;
   logic          lk_rsp_valid, lk_hit;
   logic [XW-1:0] lk_xlt;
   logic          desc_valid, desc_ready, desc_err;
   logic [63:0]   desc_w0, desc_w1;

   pasid_tlb #(.NUM_ENTRIES(N), .DID_W(DW), .PASID_W(PW), .PFN_W(FW), .XLT_W(XW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .fill_en_i(fill_en), .fill_did_i(fill_did),
      .fill_pasid_i(fill_pasid), .fill_ttype_i(fill_tt), .fill_pfn_i(fill_pfn),
      .fill_psize_i(fill_psz), .fill_xlt_i(fill_xlt), .lk_req_i(lk_req), .lk_did_i(lk_did),
      .lk_pasid_i(lk_pasid), .lk_pfn_i(lk_pfn), .lk_rsp_valid_o(lk_rsp_valid),
      .lk_hit_o(lk_hit), .lk_xlt_o(lk_xlt), .desc_valid_i(desc_valid), .desc_ready_o(desc_ready),
      .desc_w0_i(desc_w0), .desc_w1_i(desc_w1), .desc_err_o(desc_err)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; fill_en = 0; lk_req = 0; desc_valid = 0;
      fill_did = '0; fill_pasid = '0; fill_tt = '0; fill_pfn = '0; fill_psz = '0; fill_xlt = '0;
      lk_did = '0; lk_pasid = '0; lk_pfn = '0; desc_w0 = '0; desc_w1 = '0;
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic do_fill(input logic [15:0] d, input logic [19:0] p, input logic [2:0] t,
                          input logic [39:0] f, input logic [1:0] s, input logic [39:0] x);
      @(negedge clk);
      fill_en = 1; fill_did = d; fill_pasid = p; fill_tt = t; fill_pfn = f; fill_psz = s; fill_xlt = x;
      @(posedge clk); #2 fill_en = 0;
   endtask

   task automatic do_look(input logic [15:0] d, input logic [19:0] p, input logic [39:0] f,
                          output logic hit, output logic [39:0] x, output logic rv);
      @(negedge clk);
      lk_req = 1; lk_did = d; lk_pasid = p; lk_pfn = f;
      @(posedge clk); #2;
      hit = lk_hit; x = lk_xlt; rv = lk_rsp_valid;
      lk_req = 0;
   endtask

   task automatic do_desc(input logic [63:0] w0, input logic [63:0] w1,
                          output logic err, output logic rdy);
      @(negedge clk);
      while (!desc_ready) @(negedge clk);
      desc_valid = 1; desc_w0 = w0; desc_w1 = w1;
      @(posedge clk); #2;
      err = desc_err; rdy = desc_ready;
      desc_valid = 0;
   endtask

   typedef struct packed {
      logic [1:0]  op;     // 0 fill, 1 lookup, 2 descriptor
      logic [15:0] did;
      logic [19:0] pasid;
      logic [2:0]  tt;
      logic [39:0] pfn;
      logic [1:0]  psz;
      logic [5:0]  am;
      logic        hint;
      logic [1:0]  rsv;    // 1: word0 bit 3, 2: word1 bit 9, 3: word0 bit 63
      logic        expv;   // expected hit or expected error
      logic [39:0] xlt;
      logic [3:0]  req;
   } vec_t;

   function automatic vec_t mk(input int op, input int d, input int p, input int t, input longint f,
                               input int s, input int am, input int h, input int r, input int e,
                               input longint x, input int q);
      vec_t v;
      v.op = 2'(op); v.did = 16'(d); v.pasid = 20'(p); v.tt = 3'(t); v.pfn = 40'(f);
      v.psz = 2'(s); v.am = 6'(am); v.hint = 1'(h); v.rsv = 2'(r); v.expv = 1'(e);
      v.xlt = 40'(x); v.req = 4'(q);
      return v;
   endfunction

   localparam int NV = 31;
   localparam vec_t TBL [NV] = '{
      mk(0,1,5,1,'h100,0,0,0,0,0,'hA0,2),   // fills for R2
      mk(0,1,5,1,'h101,0,0,0,0,0,'hA1,2),
      mk(0,1,5,1,'h103,0,0,0,0,0,'hA2,2),
      mk(0,1,5,1,'h200,1,0,0,0,0,'hA3,2),   // 2 MiB page
      mk(0,1,5,2,'h102,0,0,0,0,0,'hA4,9),   // second-stage, R9
      mk(0,1,5,4,'h103,0,0,0,0,0,'hA5,9),   // pass-through, R9
      mk(0,2,5,1,'h100,0,0,0,0,0,'hA6,10),  // other domain, R10
      mk(0,1,6,1,'h100,0,0,0,0,0,'hA7,10),  // other PASID, R10
      mk(1,1,5,0,'h100,0,0,0,0,1,'hA0,2),   // R2 basic hit
      mk(1,1,5,0,'h3A5,0,0,0,0,1,'hA3,2),   // R2 inside large page
      mk(1,1,5,0,'h400,0,0,0,0,0,0,2),      // R2 miss past large page
      mk(1,1,5,0,'h103,0,0,0,0,1,'hA2,2),   // R2 lowest index wins
      mk(1,2,5,0,'h100,0,0,0,0,1,'hA6,3),   // R3
      mk(1,3,5,0,'h100,0,0,0,0,0,0,3),      // R3 unknown domain
      mk(1,1,7,0,'h100,0,0,0,0,0,0,3),      // R3 unknown PASID
      mk(2,1,5,0,'h100,0,2,0,1,1,0,6),      // R6 word0 reserved bit
      mk(1,1,5,0,'h100,0,0,0,0,1,'hA0,6),   // R6 nothing cleared
      mk(1,1,5,0,'h101,0,0,0,0,1,'hA1,6),
      mk(2,2,5,0,'h100,0,0,0,2,1,0,6),      // R6 word1 reserved bit
      mk(2,2,5,0,'h100,0,0,0,3,1,0,6),      // R6 word0 high reserved bit
      mk(1,2,5,0,'h100,0,0,0,0,1,'hA6,6),   // R6 survivor
      mk(2,1,5,0,'h100,0,2,1,0,0,0,11),     // R11 hint set, R5 field positions
      mk(1,1,5,0,'h100,0,0,0,0,0,0,7),      // R7 cleared in range
      mk(1,1,5,0,'h101,0,0,0,0,0,0,7),      // R7
      mk(1,1,5,0,'h103,0,0,0,0,1,'hA5,9),   // R9 pass-through kept
      mk(1,1,5,0,'h102,0,0,0,0,1,'hA4,9),   // R9 second-stage kept
      mk(1,2,5,0,'h100,0,0,0,0,1,'hA6,10),  // R10 domain kept
      mk(1,1,6,0,'h100,0,0,0,0,1,'hA7,10),  // R10 PASID kept
      mk(1,1,5,0,'h3A5,0,0,0,0,1,'hA3,7),   // R7 outside range kept
      mk(2,1,5,0,'h2A5,0,0,0,0,0,0,8),      // R8 address inside large page
      mk(1,1,5,0,'h3A5,0,0,0,0,0,0,8)       // R8 large page gone
   };

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic hit, rv, err, rdy;
      logic [39:0] x;
      do_reset();
      // R1 reset state
      #2;
      chk(desc_ready == 1'b1, "R1 ready", 64'(desc_ready), 1);
      chk(desc_err == 1'b0, "R1 err", 64'(desc_err), 0);
      chk(lk_rsp_valid == 1'b0, "R1 rsp", 64'(lk_rsp_valid), 0);
      do_look(1, 5, 'h100, hit, x, rv);
      chk(hit == 1'b0, "R1 miss", 64'(hit), 0);
      chk(rv == 1'b1, "R2 rsp valid", 64'(rv), 1);

      for (int k = 0; k < NV; k++) begin
         vec_t v;
         string tag;
         v = TBL[k];
         tag = $sformatf("R%0d row %0d", v.req, k);
         case (v.op)
            2'd0: do_fill(v.did, v.pasid, v.tt, v.pfn, v.psz, v.xlt);
            2'd1: begin
               do_look(v.did, v.pasid, v.pfn, hit, x, rv);
               chk(hit == v.expv, tag, 64'(hit), 64'(v.expv));
               if (v.expv) chk(x == v.xlt, tag, 64'(x), 64'(v.xlt));
            end
            default: begin
               logic [63:0] w0, w1;
               w0 = (64'(v.pasid) << 32) | (64'(v.did) << 16);
               w1 = (64'(v.pfn) << 12) | (64'(v.hint) << 6) | 64'(v.am);
               if (v.rsv == 2'd1) w0 = w0 | 64'h8;
               if (v.rsv == 2'd2) w1 = w1 | 64'h200;
               if (v.rsv == 2'd3) w0 = w0 | 64'h8000_0000_0000_0000;
               do_desc(w0, w1, err, rdy);
               chk(err == v.expv, tag, 64'(err), 64'(v.expv));
               chk(rdy == v.expv, {tag, " ready"}, 64'(rdy), 64'(v.expv));
            end
         endcase
      end

      // R4 placement and round-robin replacement
      do_reset();
      for (int i = 0; i < N; i++) do_fill(9, 9, 1, 40'('h10 + i), 0, 40'('h50 + i));
      do_fill(9, 9, 1, 'h20, 0, 'h70);
      do_look(9, 9, 'h10, hit, x, rv); chk(hit == 1'b0, "R4 victim 0 replaced", 64'(hit), 0);
      do_look(9, 9, 'h20, hit, x, rv); chk(hit && x == 'h70, "R4 new entry", 64'(x), 'h70);
      do_look(9, 9, 'h11, hit, x, rv); chk(hit == 1'b1, "R4 entry 1 kept", 64'(hit), 1);
      do_fill(9, 9, 1, 'h21, 0, 'h71);
      do_look(9, 9, 'h11, hit, x, rv); chk(hit == 1'b0, "R4 pointer advanced", 64'(hit), 0);
      do_look(9, 9, 'h14, hit, x, rv); chk(hit && x == 'h54, "R12 before sweep", 64'(x), 'h54);

      // R12 lookup in the sweep cycle sees the cleared state
      do_desc((64'd9 << 32) | (64'd9 << 16), 64'h14 << 12, err, rdy);
      chk(rdy == 1'b0, "R12 ready low in sweep", 64'(rdy), 0);
      do_look(9, 9, 'h14, hit, x, rv);
      chk(hit == 1'b0, "R12 sweep-cycle lookup", 64'(hit), 0);
      chk(desc_ready == 1'b1, "R12 ready back", 64'(desc_ready), 1);

      // R4 free slot preferred over pointer
      do_fill(9, 9, 1, 'h30, 0, 'h80);
      do_look(9, 9, 'h12, hit, x, rv); chk(hit && x == 'h52, "R4 free slot used", 64'(x), 'h52);
      do_look(9, 9, 'h30, hit, x, rv); chk(hit && x == 'h80, "R4 refill", 64'(x), 'h80);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule